// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block takes in serial words that an external master clocks onto a data line. The master's clock and data are brought into the system clock domain through a short flop chain. On every falling edge of the master clock one bit is taken, least significant bit first, and collected in a shift register. When the last bit of a word arrives, the word moves into a holding register that the host reads through a small register port. A one-entry queue sits behind the holding register, so a second word can arrive before the host reads the first.

Words are 8 bits long, or 9 bits when the nine-bit mode is set. The ninth bit is read from the lowest bit of the status register, and the low eight bits are read from the data register. A done flag shows that an unread word is waiting. The done flag drives an interrupt output when the receive-interrupt enable is set. The interrupt also drives a wake output while the host signals that it is asleep. Reception continues during sleep.

If a word completes while both the holding register and the queue are full, the overrun flag is set and that word is dropped. Reception then stays stopped until software clears the continuous-receive enable, which also clears the overrun flag.

Top module: `sync_slave_rx`

## Requirements
- R1: A word is received only while port enable (STAT bit 7) is 1, sync mode (MODE bit 4) is 1, master clock select (MODE bit 7) is 0 and continuous-receive enable (STAT bit 4) is 1. With any other combination, falling edges on sclk_in load nothing and FLAG bit 0 stays 0.
- R2: The single-receive enable (STAT bit 5) reads back as written and has no effect on reception in either state.
- R3: sdat_in is sampled on each falling edge of sclk_in, least significant bit first. After 8 falling edges (9 in nine-bit mode) the word is in the holding register, FLAG bit 0 (done) reads 1, and reading DATA (address 1) returns the low 8 bits.
- R4: With nine-bit mode (STAT bit 6) set, STAT bit 0 holds the ninth received bit of the word in the holding register and DATA holds bits 7..0. In 8-bit mode STAT bit 0 reads 0 for a newly received word.
- R5: irq_o is 1 exactly one cycle after the done flag and the interrupt enable (MODE bit 0) are both 1, and 0 otherwise.
- R6: wake_o is 1 one cycle after irq_o and sleep_i are both 1. sleep_i has no effect on reception.
- R7: Each read of DATA removes the oldest word. A second unread word waits in the queue and is returned by the next DATA read. The done flag clears once both entries are empty.
- R8: A word that completes while both entries are full sets overrun (STAT bit 1) and is dropped. Later words are also dropped while overrun is set.
- R9: Writing STAT bit 4 to 0 clears overrun. STAT bits 3 and 2 always read 0.
- R10: After reset, STAT, DATA and FLAG read 0x00 and irq_o and wake_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reading DATA removes a word |
| reg_addr | input | 2 | Register select: 0 STAT, 1 DATA, 2 MODE, 3 FLAG |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered, valid the cycle after reg_rd |
| sclk_in | input | 1 | Serial clock from the external master |
| sdat_in | input | 1 | Serial data line |
| sleep_i | input | 1 | High while the host core sleeps |
| irq_o | output | 1 | Receive interrupt request |
| wake_o | output | 1 | Wake-up request during sleep |

## Verification
The assertions assume that each phase of sclk_in lasts at least three system clocks, so that the synchroniser sees every falling edge. They also assume that sdat_in is stable from the rising edge until after the falling edge, and that configuration is not changed in the middle of a word. The bench holds each clock phase for four system cycles and changes data only together with the rising edge. It writes configuration only while sclk_in is idle low between words. Under these rules the stimulus sweeps every 8-bit and every 9-bit value and every combination of the enable bits.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [1:0] {
    RA_STAT = 2'd0,
    RA_DATA = 2'd1,
    RA_MODE = 2'd2,
    RA_FLAG = 2'd3
  } reg_addr_e;

  // status / control register fields (the order is visible to software)
  localparam int STAT_PEN    = 7;
  localparam int STAT_NINE   = 6;
  localparam int STAT_SINGLE = 5;
  localparam int STAT_CONT   = 4;
  localparam int STAT_FERR   = 2;
  localparam int STAT_OERR   = 1;
  localparam int STAT_BIT9   = 0;

  // mode register fields
  localparam int MODE_MASTER = 7;
  localparam int MODE_SYNC   = 4;
  localparam int MODE_IE     = 0;

  localparam int FLAG_DONE   = 0;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdat_in,
  output logic fall_o,
  output logic bit_o
);
  logic [STAGES-1:0] ck_sh;
  logic [STAGES-1:0] dt_sh;
  logic              ck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sh   <= '0;
      dt_sh   <= '0;
      ck_last <= 1'b0;
    end else begin
      ck_sh   <= {ck_sh[STAGES-2:0], sclk_in};
      dt_sh   <= {dt_sh[STAGES-2:0], sdat_in};
      ck_last <= ck_sh[STAGES-1];
    end
  end

  assign fall_o = ck_last & ~ck_sh[STAGES-1];
  assign bit_o  = dt_sh[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              nine_bit,
  input  logic              fall,
  input  logic              bit_in,
  output logic              word_valid,
  output logic [DATA_W:0]   word
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic              at_end;

  assign last   = nine_bit ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign at_end = (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (!enable) begin
      cnt  <= '0;
    end else if (fall) begin
      sreg[cnt] <= bit_in;
      cnt       <= at_end ? '0 : cnt + CNT_W'(1);
    end
  end

  always_comb begin
    word      = sreg;
    word[cnt] = bit_in;
    if (!nine_bit) word[DATA_W] = 1'b0;
  end

  assign word_valid = enable & fall & at_end;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DATA_W));
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [DATA_W:0] push_word,
  input  logic            pop,
  input  logic            clr_ovr,
  output logic [DATA_W:0] hold_word,
  output logic            hold_valid,
  output logic            ovr
);
  logic [DATA_W:0] queue_q, hold_n, queue_n;
  logic            qv_q, hv_n, qv_n, ov_n;

  always_comb begin
    hold_n  = hold_word;
    hv_n    = hold_valid;
    queue_n = queue_q;
    qv_n    = qv_q;
    ov_n    = ovr;
    if (pop && hold_valid) begin
      if (qv_q) hold_n = queue_q;
      hv_n = qv_q;
      qv_n = 1'b0;
    end
    if (push) begin
      if (!hv_n) begin
        hold_n = push_word;
        hv_n   = 1'b1;
      end else if (!qv_n) begin
        queue_n = push_word;
        qv_n    = 1'b1;
      end else begin
        ov_n = 1'b1;
      end
    end
    if (clr_ovr) ov_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word  <= '0;
      hold_valid <= 1'b0;
      queue_q    <= '0;
      qv_q       <= 1'b0;
      ovr        <= 1'b0;
    end else begin
      hold_word  <= hold_n;
      hold_valid <= hv_n;
      queue_q    <= queue_n;
      qv_q       <= qv_n;
      ovr        <= ov_n;
    end
  end

  p_queue_behind_hold_r7: assert property (@(posedge clk) disable iff (rst)
    qv_q |-> hold_valid);
  p_ovr_only_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(hold_valid && qv_q));
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic              sleep_i,
  output logic              irq_o,
  output logic              wake_o
);
  logic port_en, nine_bit, single_en, cont_en;
  logic master_clk, sync_mode, rx_ie;
  logic fall, samp_bit, word_valid, hold_valid, ovr, rx_active, pop;
  logic [DATA_W:0] word, hold_word;
  reg_addr_e addr;

  assign addr      = reg_addr_e'(reg_addr);
  assign rx_active = port_en & sync_mode & ~master_clk & cont_en & ~ovr;
  assign pop       = reg_rd & (addr == RA_DATA);

  sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .fall_o(fall), .bit_o(samp_bit)
  );

  rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .enable(rx_active), .nine_bit(nine_bit),
    .fall(fall), .bit_in(samp_bit), .word_valid(word_valid), .word(word)
  );

  rx_hold_queue #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .push(word_valid), .push_word(word), .pop(pop),
    .clr_ovr(~cont_en), .hold_word(hold_word), .hold_valid(hold_valid),
    .ovr(ovr)
  );

  // control register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      port_en    <= 1'b0;
      nine_bit   <= 1'b0;
      single_en  <= 1'b0;
      cont_en    <= 1'b0;
      master_clk <= 1'b0;
      sync_mode  <= 1'b0;
      rx_ie      <= 1'b0;
    end else if (reg_wr) begin
      if (addr == RA_STAT) begin
        port_en   <= reg_wdata[STAT_PEN];
        nine_bit  <= reg_wdata[STAT_NINE];
        single_en <= reg_wdata[STAT_SINGLE];
        cont_en   <= reg_wdata[STAT_CONT];
      end
      if (addr == RA_MODE) begin
        master_clk <= reg_wdata[MODE_MASTER];
        sync_mode  <= reg_wdata[MODE_SYNC];
        rx_ie      <= reg_wdata[MODE_IE];
      end
    end
  end

  logic [DATA_W-1:0] stat_v, mode_v, flag_v;
  always_comb begin
    stat_v = '0;
    stat_v[STAT_PEN]    = port_en;
    stat_v[STAT_NINE]   = nine_bit;
    stat_v[STAT_SINGLE] = single_en;
    stat_v[STAT_CONT]   = cont_en;
    stat_v[STAT_OERR]   = ovr;
    stat_v[STAT_BIT9]   = hold_word[DATA_W];
    mode_v = '0;
    mode_v[MODE_MASTER] = master_clk;
    mode_v[MODE_SYNC]   = sync_mode;
    mode_v[MODE_IE]     = rx_ie;
    flag_v = '0;
    flag_v[FLAG_DONE]   = hold_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      if (reg_rd) begin
        case (addr)
          RA_STAT: reg_rdata <= stat_v;
          RA_DATA: reg_rdata <= hold_word[DATA_W-1:0];
          RA_MODE: reg_rdata <= mode_v;
          default: reg_rdata <= flag_v;
        endcase
      end
      irq_o  <= hold_valid & rx_ie;
      wake_o <= irq_o & sleep_i;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  p_rx_needs_enable_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_valid) |-> $past(rx_active));
  p_irq_needs_word_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(hold_valid && rx_ie));
  p_wake_in_sleep_r6: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(sleep_i));
  p_no_word_in_ovr_r8: assert property (@(posedge clk) disable iff (rst)
    ovr |-> !word_valid);
  p_ovr_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    !cont_en |=> !ovr);
endmodule

// File: tb/sync_slave_rx_bench.sv
module sync_slave_rx_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic sclk_in = 1'b0, sdat_in = 1'b0, sleep_i = 1'b0;
  logic irq_o, wake_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_slave_rx u_sync_slave_rx (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_in(sclk_in), .sdat_in(sdat_in), .sleep_i(sleep_i),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic send(input int val, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sdat_in = val[i];
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
      sclk_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 irq", int'(irq_o), 0);
    chk("R10 wake", int'(wake_o), 0);
    rd(2'd0, v); chk("R10 STAT", v, 8'h00);
    rd(2'd1, v); chk("R10 DATA", v, 8'h00);
    rd(2'd3, v); chk("R10 FLAG", v, 8'h00);

    // R3: every 8-bit value, LSB first
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h90);
    for (int x = 0; x < 256; x++) begin
      send(x, 8);
      rd(2'd3, v); chk("R3 done set", v, 1);
      rd(2'd0, v); chk("R4 STAT 8-bit", v, 8'h90);
      rd(2'd1, v); chk("R3 DATA", v, x);
      rd(2'd3, v); chk("R7 done clear", v, 0);
    end

    // R4: every 9-bit value
    wr(2'd0, 8'hD0);
    for (int x = 0; x < 512; x++) begin
      send(x, 9);
      rd(2'd0, v); chk("R4 ninth bit", v, 8'hD0 | (x >> 8));
      rd(2'd1, v); chk("R4 low bits", v, x & 8'hFF);
    end

    // R7: queue of one behind holding register
    wr(2'd0, 8'h90);
    send(8'h11, 8); send(8'h22, 8);
    rd(2'd3, v); chk("R7 done two words", v, 1);
    rd(2'd0, v); chk("R7 no overrun", v, 8'h90);
    rd(2'd1, v); chk("R7 first word", v, 8'h11);
    rd(2'd3, v); chk("R7 done one left", v, 1);
    rd(2'd1, v); chk("R7 second word", v, 8'h22);
    rd(2'd3, v); chk("R7 done empty", v, 0);

    // R8: overrun drops the third word and blocks later ones
    send(8'h33, 8); send(8'h44, 8); send(8'h55, 8);
    rd(2'd0, v); chk("R8 overrun set", v, 8'h92);
    send(8'h66, 8);
    rd(2'd1, v); chk("R8 oldest kept", v, 8'h33);
    rd(2'd1, v); chk("R8 queue kept", v, 8'h44);
    rd(2'd3, v); chk("R8 dropped words", v, 0);
    rd(2'd0, v); chk("R8 overrun sticky", v, 8'h92);
    // R9: clearing continuous enable clears overrun
    wr(2'd0, 8'h80);
    rd(2'd0, v); chk("R9 overrun cleared", v, 8'h80);
    wr(2'd0, 8'h9F);
    rd(2'd0, v); chk("R9 bits 3 2 read 0", v, 8'h90);
    send(8'h77, 8);
    rd(2'd1, v); chk("R9 receive resumes", v, 8'h77);

    // R1: all enable combinations
    for (int c = 0; c < 16; c++) begin
      wr(2'd2, {c[2], 2'b00, c[1], 4'b0000});
      wr(2'd0, {c[0], 2'b00, c[3], 4'b0000});
      send(8'hA5, 8);
      rd(2'd3, v); chk("R1 enable gating", v, (c == 11) ? 1 : 0);
      if (v[0]) begin
        rd(2'd1, v); chk("R1 word", v, 8'hA5);
      end
    end

    // R2: single-receive enable ignored
    wr(2'd2, 8'h10);
    wr(2'd0, 8'hB0);
    rd(2'd0, v); chk("R2 readback", v, 8'hB0);
    send(8'h3C, 8);
    rd(2'd3, v); chk("R2 set still receives", v, 1);
    rd(2'd1, v); chk("R2 word", v, 8'h3C);
    wr(2'd0, 8'hA0);
    send(8'h3D, 8);
    rd(2'd3, v); chk("R2 set alone does not receive", v, 0);

    // R5: interrupt gating
    wr(2'd0, 8'h90);
    send(8'h5A, 8);
    chk("R5 irq masked", int'(irq_o), 0);
    wr(2'd2, 8'h11);
    repeat (2) @(negedge clk);
    chk("R5 irq raised", int'(irq_o), 1);
    rd(2'd2, v); chk("R5 MODE readback", v, 8'h11);
    rd(2'd1, v); chk("R5 word", v, 8'h5A);
    repeat (2) @(negedge clk);
    chk("R5 irq dropped", int'(irq_o), 0);

    // R6: wake during sleep, reception continues
    sleep_i = 1'b1;
    send(8'hC3, 8);
    chk("R6 wake", int'(wake_o), 1);
    rd(2'd3, v); chk("R6 received asleep", v, 1);
    rd(2'd1, v); chk("R6 word", v, 8'hC3);
    repeat (3) @(negedge clk);
    chk("R6 wake cleared", int'(wake_o), 0);
    sleep_i = 1'b0;

    summary();
  end
endmodule